// File: doc/BRIEF.md
# Trap return unit

This block resolves a return-from-trap request on a core with user, supervisor and machine privilege. A request names its kind: a machine return or a supervisor return. It also carries the current privilege, the status word, both saved exception PCs, and a flag that says whether 16-bit (compressed) instructions are enabled. One clock later the block presents the outcome. The outcome is either a redirect target with the new privilege and the updated status word, or a refusal with an exception cause code.

For an accepted return, the block pops the interrupt-enable stack of the chosen level. It also resets that level's saved previous mode to user, and it turns the old saved mode into the next privilege. A saved mode that holds the reserved encoding is treated as user. A refused return changes nothing: the status word and the privilege come back exactly as they went in. The caller owns the fetch redirect and the trap entry that follows a refusal.

Top module: `trapret_unit`

## Requirements
- R1: Every output is a register. When `rst` is high, every output reads zero at the next rising edge. A request sampled at a rising edge gives `rsp_valid` = 1 after that same edge. With no request, `rsp_valid` and `exc_valid` read 0.
- R2: A supervisor return (`ret_is_m` = 0) made while `cur_priv` = 2'b00 (user) is refused with `exc_cause` = 2. Privilege encodings are user 2'b00, supervisor 2'b01 and machine 2'b11.
- R3: A machine return (`ret_is_m` = 1) made while `cur_priv` is anything other than 2'b11 is refused with `exc_cause` = 2.
- R4: A return that passes the privilege check is refused with `exc_cause` = 0 when `rvc_en` = 0 and bits [1:0] of the selected saved PC are nonzero. The privilege refusal takes priority over this one.
- R5: When `rvc_en` = 1, nonzero low bits in the saved PC do not cause a refusal.
- R6: An accepted machine return writes bit 7 of the status word into bit 3, clears bit 7, and clears bits [12:11]. All other bits pass through unchanged.
- R7: An accepted supervisor return writes bit 5 of the status word into bit 1, clears bit 5, and clears bit 8. All other bits pass through unchanged.
- R8: The next privilege after a machine return is the old bits [12:11]. After a supervisor return it is {1'b0, old bit 8}. An old value of 2'b10 becomes 2'b00.
- R9: On acceptance, `next_pc` is `mepc_in` for a machine return and `sepc_in` for a supervisor return. On refusal, `next_pc` is zero.
- R10: On refusal, `exc_valid` = 1, `status_out` equals the incoming status word, and `next_priv` equals `cur_priv`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | A return request is present this cycle |
| ret_is_m | input | 1 | 1 = machine return, 0 = supervisor return |
| cur_priv | input | 2 | Current privilege |
| status_in | input | XLEN | Current status word |
| mepc_in | input | XLEN | Saved machine exception PC |
| sepc_in | input | XLEN | Saved supervisor exception PC |
| rvc_en | input | 1 | Compressed instructions enabled |
| rsp_valid | output | 1 | Result of the previous cycle's request |
| next_pc | output | XLEN | Return target, or zero when refused |
| next_priv | output | 2 | Privilege after the return |
| status_out | output | XLEN | Status word after the return |
| exc_valid | output | 1 | The return was refused |
| exc_cause | output | CAUSE_W | Refusal cause: 2 for illegal, 0 for misaligned |

## Verification
All state passes through a single register stage, so a wrong internal decision shows up on the ports in the cycle right after the request. A wrong privilege or alignment decision appears as a wrong `exc_valid` or `exc_cause`. Taking the stack from the wrong level shows up as a changed bit outside the expected field set in `status_out`. Choosing the wrong saved PC is exposed because the stimulus gives the unselected PC misaligned low bits. The reserved-mode mapping and the refusal priority each have their own vectors.

// File: rtl/trapret_pkg.sv
package trapret_pkg;
  typedef enum logic [1:0] {
    PRIV_U    = 2'b00,
    PRIV_S    = 2'b01,
    PRIV_RSVD = 2'b10,
    PRIV_M    = 2'b11
  } priv_e;

  // status word bit positions
  localparam int ST_SIE  = 1;
  localparam int ST_MIE  = 3;
  localparam int ST_SPIE = 5;
  localparam int ST_MPIE = 7;
  localparam int ST_SPP  = 8;
  localparam int ST_MPP  = 11;  // two bits: [12:11]
  localparam int ST_MIN_W = 13;

  localparam int CAUSE_MISALIGN = 0;
  localparam int CAUSE_ILLEGAL  = 2;
endpackage

// File: rtl/trapret_gate.sv
module trapret_gate
  import trapret_pkg::*;
#(
  parameter int CAUSE_W = 4
) (
  input  logic               is_m,
  input  logic [1:0]         priv,
  input  logic [1:0]         pc_low,
  input  logic               rvc_en,
  output logic               refuse,
  output logic [CAUSE_W-1:0] cause
);
  logic priv_ok;
  logic align_bad;

  always_comb begin
    if (is_m) priv_ok = (priv == PRIV_M);
    else      priv_ok = (priv == PRIV_S) || (priv == PRIV_M);
    align_bad = !rvc_en && (pc_low != 2'b00);
    refuse    = !priv_ok || align_bad;
    if (!priv_ok) cause = CAUSE_W'(CAUSE_ILLEGAL);
    else          cause = CAUSE_W'(CAUSE_MISALIGN);
  end
endmodule

// File: rtl/trapret_stack.sv
module trapret_stack
  import trapret_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic            is_m,
  input  logic [XLEN-1:0] st_in,
  output logic [XLEN-1:0] st_new,
  output logic [1:0]      priv_new
);
  logic [1:0] saved_mode;

  always_comb begin
    st_new = st_in;
    if (is_m) begin
      saved_mode               = st_in[ST_MPP +: 2];
      st_new[ST_MIE]           = st_in[ST_MPIE];
      st_new[ST_MPIE]          = 1'b0;
      st_new[ST_MPP +: 2]      = PRIV_U;
    end else begin
      saved_mode               = {1'b0, st_in[ST_SPP]};
      st_new[ST_SIE]           = st_in[ST_SPIE];
      st_new[ST_SPIE]          = 1'b0;
      st_new[ST_SPP]           = 1'b0;
    end
    priv_new = (saved_mode == PRIV_RSVD) ? PRIV_U : saved_mode;
  end
endmodule

// File: rtl/trapret_unit.sv
module trapret_unit
  import trapret_pkg::*;
#(
  parameter int XLEN    = 32,
  parameter int CAUSE_W = 4
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               req_valid,
  input  logic               ret_is_m,
  input  logic [1:0]         cur_priv,
  input  logic [XLEN-1:0]    status_in,
  input  logic [XLEN-1:0]    mepc_in,
  input  logic [XLEN-1:0]    sepc_in,
  input  logic               rvc_en,
  output logic               rsp_valid,
  output logic [XLEN-1:0]    next_pc,
  output logic [1:0]         next_priv,
  output logic [XLEN-1:0]    status_out,
  output logic               exc_valid,
  output logic [CAUSE_W-1:0] exc_cause
);
  logic [XLEN-1:0]    target;
  logic               g_refuse;
  logic [CAUSE_W-1:0] g_cause;
  logic [XLEN-1:0]    s_new;
  logic [1:0]         p_new;

  initial begin
    if (XLEN < ST_MIN_W) $error("XLEN too small for status layout");
    if (CAUSE_W < 2)     $error("CAUSE_W too small for cause codes");
  end

  assign target = ret_is_m ? mepc_in : sepc_in;

  trapret_gate #(.CAUSE_W(CAUSE_W)) u_gate (
    .is_m   (ret_is_m),
    .priv   (cur_priv),
    .pc_low (target[1:0]),
    .rvc_en (rvc_en),
    .refuse (g_refuse),
    .cause  (g_cause)
  );

  trapret_stack #(.XLEN(XLEN)) u_stack (
    .is_m     (ret_is_m),
    .st_in    (status_in),
    .st_new   (s_new),
    .priv_new (p_new)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid  <= 1'b0;
      exc_valid  <= 1'b0;
      exc_cause  <= '0;
      next_pc    <= '0;
      next_priv  <= '0;
      status_out <= '0;
    end else begin
      rsp_valid <= req_valid;
      exc_valid <= req_valid && g_refuse;
      if (req_valid) begin
        exc_cause  <= g_refuse ? g_cause : '0;
        next_pc    <= g_refuse ? '0 : target;
        status_out <= g_refuse ? status_in : s_new;
        next_priv  <= g_refuse ? cur_priv : p_new;
      end
    end
  end

  // R1: a response follows each request by one cycle, and only then
  assert_resp_latency_R1: assert property (@(posedge clk) disable iff (rst)
    req_valid |=> rsp_valid);
  assert_no_idle_resp_R1: assert property (@(posedge clk) disable iff (rst)
    !req_valid |=> (!rsp_valid && !exc_valid));

  // R3: a machine return outside machine mode is refused as illegal
  assert_mret_illegal_R3: assert property (@(posedge clk) disable iff (rst)
    (req_valid && ret_is_m && cur_priv != PRIV_M)
    |=> (exc_valid && exc_cause == CAUSE_W'(CAUSE_ILLEGAL)));

  // R2: a supervisor return from user mode is refused as illegal
  assert_sret_illegal_R2: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !ret_is_m && cur_priv == PRIV_U)
    |=> (exc_valid && exc_cause == CAUSE_W'(CAUSE_ILLEGAL)));

  // R4: a legal machine return with a misaligned target and no compressed support
  assert_mret_misalign_R4: assert property (@(posedge clk) disable iff (rst)
    (req_valid && ret_is_m && cur_priv == PRIV_M && !rvc_en && mepc_in[1:0] != 2'b00)
    |=> (exc_valid && exc_cause == CAUSE_W'(CAUSE_MISALIGN)));

  // R10: a refusal hands the state back untouched
  assert_refuse_keeps_R10: assert property (@(posedge clk) disable iff (rst)
    req_valid |=> (!exc_valid ||
      (status_out == $past(status_in) && next_priv == $past(cur_priv) && next_pc == '0)));

  // R8: an accepted return never lands in the reserved mode
  assert_no_rsvd_priv_R8: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && !exc_valid) |-> (next_priv != PRIV_RSVD));
endmodule

// File: tb/tb_trapret_unit.sv
module tb_trapret_unit;
  localparam int XLEN = 32;
  localparam int CW   = 4;
  localparam logic [18:0] UPPER = 19'h4B3C1;
  localparam logic [XLEN-1:0] MBASE = 32'h8000_0100;
  localparam logic [XLEN-1:0] SBASE = 32'h4000_0200;

  typedef struct packed {
    logic        is_m;
    logic [1:0]  priv;
    logic [12:0] st;
    logic [1:0]  pcl;
    logic        rvc;
    logic        ex;
    logic [3:0]  cause;
    logic [1:0]  np;
  } vec_t;

  localparam int NV = 14;
  localparam vec_t TBL [NV] = '{
    '{1'b1, 2'b11, 13'h1880, 2'b00, 1'b0, 1'b0, 4'd0, 2'b11}, // R6 R8 back to machine
    '{1'b1, 2'b11, 13'h0808, 2'b00, 1'b0, 1'b0, 4'd0, 2'b01}, // R6 R8 to supervisor
    '{1'b1, 2'b11, 13'h1000, 2'b00, 1'b0, 1'b0, 4'd0, 2'b00}, // R8 reserved mode to user
    '{1'b1, 2'b11, 13'h0080, 2'b10, 1'b1, 1'b0, 4'd0, 2'b00}, // R5 misaligned allowed
    '{1'b1, 2'b11, 13'h1880, 2'b10, 1'b0, 1'b1, 4'd0, 2'b11}, // R4 misaligned refused
    '{1'b1, 2'b01, 13'h1880, 2'b00, 1'b0, 1'b1, 4'd2, 2'b01}, // R3 from supervisor
    '{1'b1, 2'b00, 13'h0880, 2'b01, 1'b0, 1'b1, 4'd2, 2'b00}, // R3 R4 illegal wins
    '{1'b0, 2'b01, 13'h0120, 2'b00, 1'b0, 1'b0, 4'd0, 2'b01}, // R7 R8 to supervisor
    '{1'b0, 2'b11, 13'h0002, 2'b00, 1'b0, 1'b0, 4'd0, 2'b00}, // R7 from machine
    '{1'b0, 2'b00, 13'h0120, 2'b00, 1'b0, 1'b1, 4'd2, 2'b00}, // R2 from user
    '{1'b0, 2'b01, 13'h0120, 2'b01, 1'b0, 1'b1, 4'd0, 2'b01}, // R4 supervisor misaligned
    '{1'b0, 2'b11, 13'h1FFF, 2'b11, 1'b1, 1'b0, 4'd0, 2'b01}, // R5 R7 all ones
    '{1'b1, 2'b11, 13'h1FFF, 2'b00, 1'b0, 1'b0, 4'd0, 2'b11}, // R6 all ones
    '{1'b1, 2'b10, 13'h0000, 2'b00, 1'b0, 1'b1, 4'd2, 2'b10}  // R3 R10 reserved current
  };

  logic            clk = 1'b0;
  logic            rst;
  logic            req_valid, ret_is_m, rvc_en;
  logic [1:0]      cur_priv;
  logic [XLEN-1:0] status_in, mepc_in, sepc_in;
  logic            rsp_valid, exc_valid;
  logic [XLEN-1:0] next_pc, status_out;
  logic [1:0]      next_priv;
  logic [CW-1:0]   exc_cause;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;

  trapret_unit #(.XLEN(XLEN), .CAUSE_W(CW)) dut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .ret_is_m(ret_is_m),
    .cur_priv(cur_priv), .status_in(status_in), .mepc_in(mepc_in),
    .sepc_in(sepc_in), .rvc_en(rvc_en), .rsp_valid(rsp_valid),
    .next_pc(next_pc), .next_priv(next_priv), .status_out(status_out),
    .exc_valid(exc_valid), .exc_cause(exc_cause)
  );

  task automatic check(input string tag, input logic [XLEN-1:0] got,
                       input logic [XLEN-1:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  function automatic logic [XLEN-1:0] model_status(input logic m, input logic ex,
                                                   input logic [XLEN-1:0] s);
    logic [XLEN-1:0] r = s;
    if (!ex) begin
      if (m) begin r[3] = s[7]; r[7] = 1'b0; r[12:11] = 2'b00; end
      else   begin r[1] = s[5]; r[5] = 1'b0; r[8] = 1'b0; end
    end
    return r;
  endfunction

  task automatic drive(input vec_t v);
    req_valid = 1'b1;
    ret_is_m  = v.is_m;
    cur_priv  = v.priv;
    status_in = {UPPER, v.st};
    rvc_en    = v.rvc;
    // the unselected PC is always misaligned so a wrong choice shows
    mepc_in   = v.is_m ? (MBASE | XLEN'(v.pcl)) : (MBASE | 32'h2);
    sepc_in   = v.is_m ? (SBASE | 32'h2) : (SBASE | XLEN'(v.pcl));
  endtask

  task automatic expect_vec(input vec_t v);
    logic [XLEN-1:0] epc;
    epc = v.is_m ? (MBASE | XLEN'(v.pcl)) : (SBASE | XLEN'(v.pcl));
    check("R1 rsp_valid", XLEN'(rsp_valid), 1);
    check("R2 R3 R4 R5 exc_valid", XLEN'(exc_valid), XLEN'(v.ex));
    check("R2 R3 R4 exc_cause", XLEN'(exc_cause), XLEN'(v.cause));
    check("R8 R10 next_priv", XLEN'(next_priv), XLEN'(v.np));
    check("R6 R7 R10 status_out", status_out,
          model_status(v.is_m, v.ex, {UPPER, v.st}));
    check("R9 next_pc", next_pc, v.ex ? '0 : epc);
  endtask

  initial begin
    rst = 1'b1; req_valid = 1'b0; ret_is_m = 1'b0; rvc_en = 1'b0;
    cur_priv = 2'b11; status_in = '1; mepc_in = '1; sepc_in = '1;
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 reset rsp_valid", XLEN'(rsp_valid), 0);
    check("R1 reset exc_valid", XLEN'(exc_valid), 0);
    check("R1 reset next_pc", next_pc, 0);
    check("R1 reset status_out", status_out, 0);
    check("R1 reset next_priv", XLEN'(next_priv), 0);
    rst = 1'b0;

    // table walk, one request per cycle
    for (int i = 0; i < NV; i++) begin
      drive(TBL[i]);
      @(negedge clk);
      expect_vec(TBL[i]);
    end

    // R1 idle after a response
    req_valid = 1'b0;
    @(negedge clk);
    check("R1 idle rsp_valid", XLEN'(rsp_valid), 0);
    check("R1 idle exc_valid", XLEN'(exc_valid), 0);

    // R10 a refusal right after an acceptance returns the raw state
    drive(TBL[0]);
    @(negedge clk);
    expect_vec(TBL[0]);
    drive(TBL[5]);
    @(negedge clk);
    expect_vec(TBL[5]);

    // R1 reset in mid-stream clears the outputs
    drive(TBL[1]);
    rst = 1'b1;
    @(negedge clk);
    check("R1 mid reset rsp_valid", XLEN'(rsp_valid), 0);
    check("R1 mid reset status_out", status_out, 0);
    rst = 1'b0;
    req_valid = 1'b0;
    @(negedge clk);

    done = 1'b1;
    $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule